// File: doc/BRIEF.md
# Pre-adder multiply-add slice

This block is a pipelined signed arithmetic slice. It narrows a wide first operand to the multiplier width, can add a second operand to it, multiplies the result by a third operand and adds one of several addends to the product. The addend is zero, a wide direct operand, a cascade operand arriving from a neighbouring slice, or the slice's own registered result. Selecting its own result turns the slice into a multiply-accumulator.

Several slices can be chained: the result leaves on a cascade output that feeds the cascade input of the next slice, so sums of products can be built without fabric adders. Each pipeline stage (first-operand/multiplier-operand input, pre-adder second operand, product, result) is kept or removed by its own parameter. This trades latency against clock rate. A synchronous clock enable freezes the whole pipeline, and a synchronous reset clears it.

Top module: `premul_slice`

## Requirements
- R1: With every stage kept, `p_out` equals the wrapped 48-bit signed value `pre * b_in + addend`, three enabled clock edges after the operands are applied.
- R2: When `use_pre` is 1 the multiplier operand `pre` is `a_in[24:0] + d_in`, wrapped to 25 signed bits; when `use_pre` is 0 it is `a_in[24:0]`. Bits `a_in[29:25]` never affect the result.
- R3: The multiply is signed 25 x 18. Its 43-bit product is sign-extended to 48 bits, so (-2^24) x (-2^17) gives +2^41.
- R4: `add_sel` picks the addend: 0 selects zero, 1 selects `c_in`, 2 selects `casc_in`, and 3 selects the current result (accumulation). When the result stage is removed, code 3 adds zero.
- R5: `casc_out` is always equal to `p_out`.
- R6: Latency is AREG + MREG + PREG enabled edges. `b_in`, `use_pre`, `add_sel`, `c_in` and `casc_in` travel with `a_in`, and `d_in` is delayed by DREG. With AREG = MREG = 0 and PREG = 1 the latency is one edge.
- R7: A high `rst` at a clock edge clears every kept register to zero, whatever `ce` is. With the result stage kept, `p_out` reads 0 after that edge.
- R8: With `ce` low and `rst` low, no register changes and `p_out` holds its value.
- R9: The final sum wraps modulo 2^48. For example, 0x7FFF_FFFF_FFFF + 1 gives 0x8000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Synchronous clock enable for all registers |
| a_in | input | 30 | First pre-adder operand; only the low 25 bits are used |
| d_in | input | 25 | Second pre-adder operand |
| b_in | input | 18 | Second multiplier operand |
| c_in | input | 48 | Direct addend |
| casc_in | input | 48 | Cascade addend from a previous slice |
| use_pre | input | 1 | 1 adds `d_in` to the first operand |
| add_sel | input | 2 | Addend select: 0 zero, 1 C, 2 cascade, 3 own result |
| p_out | output | 48 | Result |
| casc_out | output | 48 | Cascade result to the next slice |

## Verification
The tricky overlaps are accumulation feedback with reset, and accumulation feedback with a frozen pipeline. In both cases the result register would otherwise take in its own value and a new product on the same edge. The random phase keeps `add_sel` = 3 frequent and drops `ce` in about one cycle in seven. It raises `rst` at random points inside accumulation runs. A bench model, advanced only on enabled edges and cleared on reset, gives the expected result for a default slice and for a one-stage slice every cycle, so a lost or doubled accumulation shows up as a mismatch.

// File: rtl/premul_pkg.sv
`timescale 1ns/1ps
package premul_pkg;
  typedef enum logic [1:0] {
    ADD_ZERO = 2'd0,
    ADD_C    = 2'd1,
    ADD_CASC = 2'd2,
    ADD_P    = 2'd3
  } add_sel_e;
endpackage

// File: rtl/premul_pipe.sv
`timescale 1ns/1ps
// Optional pipeline register: kept when EN is set, a wire otherwise.
module premul_pipe #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)     r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;

      assert_stage_clear_R7: assert property (@(posedge clk) rst |=> (q == '0));
      assert_stage_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));
    end else begin : g_wire
      assign q = d;
      logic unused_seq;
      assign unused_seq = ^{clk, rst, ce};
    end
  endgenerate
endmodule

// File: rtl/premul_preadd.sv
`timescale 1ns/1ps
// Narrowing pre-adder: low N_W bits of A, optionally plus D, wrapped to N_W bits.
module premul_preadd #(
  parameter int A_W = 30,
  parameter int N_W = 25
) (
  input  logic [A_W-1:0] a,
  input  logic [N_W-1:0] d,
  input  logic           use_pre,
  output logic [N_W-1:0] pre
);
  logic [N_W-1:0] a_lo;
  assign a_lo = a[N_W-1:0];

  logic unused_ahi;
  assign unused_ahi = ^a[A_W-1:N_W];

  always_comb begin
    if (use_pre) pre = a_lo + d;
    else         pre = a_lo;
  end
endmodule

// File: rtl/premul_mult.sv
`timescale 1ns/1ps
// Signed multiplier with optional product stage; addend controls ride alongside.
module premul_mult #(
  parameter int N_W  = 25,
  parameter int B_W  = 18,
  parameter int P_W  = 48,
  parameter int MREG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [N_W-1:0] pre,
  input  logic [B_W-1:0] b,
  input  logic [1:0]     sel,
  input  logic [P_W-1:0] c_op,
  input  logic [P_W-1:0] casc_op,
  output logic [P_W-1:0] prod_q,
  output logic [1:0]     sel_q,
  output logic [P_W-1:0] c_q,
  output logic [P_W-1:0] casc_q
);
  localparam int BUN_W = 3 * P_W + 2;

  logic signed [P_W-1:0] pre_x, b_x, prod_c;
  assign pre_x  = $signed({{(P_W-N_W){pre[N_W-1]}}, pre});
  assign b_x    = $signed({{(P_W-B_W){b[B_W-1]}}, b});
  assign prod_c = pre_x * b_x;

  logic [BUN_W-1:0] bun_d, bun_q;
  assign bun_d = {prod_c, sel, c_op, casc_op};

  premul_pipe #(.W(BUN_W), .EN(MREG != 0)) u_mreg (
    .clk(clk), .rst(rst), .ce(ce), .d(bun_d), .q(bun_q)
  );

  assign {prod_q, sel_q, c_q, casc_q} = bun_q;

  assert_zero_factor_R3: assert property (@(posedge clk) disable iff (rst)
    ((pre == '0) || (b == '0)) |-> (prod_c == '0));
endmodule

// File: rtl/premul_post.sv
`timescale 1ns/1ps
// Final adder with addend select and optional result register.
module premul_post
  import premul_pkg::*;
#(
  parameter int P_W  = 48,
  parameter int PREG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [P_W-1:0] prod,
  input  logic [1:0]     sel,
  input  logic [P_W-1:0] c_op,
  input  logic [P_W-1:0] casc_op,
  output logic [P_W-1:0] p
);
  logic [P_W-1:0] fb, addend, sum;

  always_comb begin
    case (add_sel_e'(sel))
      ADD_ZERO: addend = '0;
      ADD_C:    addend = c_op;
      ADD_CASC: addend = casc_op;
      default:  addend = fb;
    endcase
  end

  assign sum = prod + addend;

  generate
    if (PREG != 0) begin : g_preg
      logic [P_W-1:0] p_r;
      always_ff @(posedge clk) begin
        if (rst)     p_r <= '0;
        else if (ce) p_r <= sum;
      end
      assign p  = p_r;
      assign fb = p_r;

      assert_result_clear_R7: assert property (@(posedge clk) rst |=> (p == '0));
      assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(p));
      assert_accum_zero_prod_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && sel == 2'd3 && prod == '0) |=> $stable(p));
      assert_zero_addend_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && sel == 2'd0 && prod == '0) |=> (p == '0));
    end else begin : g_nopreg
      assign p  = sum;
      assign fb = '0;
      logic unused_seq;
      assign unused_seq = ^{clk, rst, ce};
    end
  endgenerate
endmodule

// File: rtl/premul_slice.sv
`timescale 1ns/1ps
// Pre-adder multiply-add slice: P = (A[lo] (+ D)) * B + {0, C, CASC, P}.
module premul_slice #(
  parameter int A_W  = 30,
  parameter int D_W  = 25,
  parameter int B_W  = 18,
  parameter int P_W  = 48,
  parameter int AREG = 1,
  parameter int DREG = 1,
  parameter int MREG = 1,
  parameter int PREG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [A_W-1:0] a_in,
  input  logic [D_W-1:0] d_in,
  input  logic [B_W-1:0] b_in,
  input  logic [P_W-1:0] c_in,
  input  logic [P_W-1:0] casc_in,
  input  logic           use_pre,
  input  logic [1:0]     add_sel,
  output logic [P_W-1:0] p_out,
  output logic [P_W-1:0] casc_out
);
  localparam int S1_W = A_W + B_W + 1 + 2 + 2 * P_W;

  // Input stage: A with everything that must stay aligned to it.
  logic [S1_W-1:0] s1_d, s1_q;
  assign s1_d = {a_in, b_in, use_pre, add_sel, c_in, casc_in};

  premul_pipe #(.W(S1_W), .EN(AREG != 0)) u_areg (
    .clk(clk), .rst(rst), .ce(ce), .d(s1_d), .q(s1_q)
  );

  logic [D_W-1:0] d_q;
  premul_pipe #(.W(D_W), .EN(DREG != 0)) u_dreg (
    .clk(clk), .rst(rst), .ce(ce), .d(d_in), .q(d_q)
  );

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           pre_en_q;
  logic [1:0]     sel_q1;
  logic [P_W-1:0] c_q1, casc_q1;
  assign {a_q, b_q, pre_en_q, sel_q1, c_q1, casc_q1} = s1_q;

  logic [D_W-1:0] pre;
  premul_preadd #(.A_W(A_W), .N_W(D_W)) u_pre (
    .a(a_q), .d(d_q), .use_pre(pre_en_q), .pre(pre)
  );

  logic [P_W-1:0] prod_q2, c_q2, casc_q2;
  logic [1:0]     sel_q2;
  premul_mult #(.N_W(D_W), .B_W(B_W), .P_W(P_W), .MREG(MREG)) u_mul (
    .clk(clk), .rst(rst), .ce(ce),
    .pre(pre), .b(b_q), .sel(sel_q1), .c_op(c_q1), .casc_op(casc_q1),
    .prod_q(prod_q2), .sel_q(sel_q2), .c_q(c_q2), .casc_q(casc_q2)
  );

  premul_post #(.P_W(P_W), .PREG(PREG)) u_post (
    .clk(clk), .rst(rst), .ce(ce),
    .prod(prod_q2), .sel(sel_q2), .c_op(c_q2), .casc_op(casc_q2), .p(p_out)
  );

  assign casc_out = p_out;
endmodule

// File: tb/sim_premul_slice.sv
`timescale 1ns/1ps
module sim_premul_slice;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic [29:0] a_in = '0;
  logic [24:0] d_in = '0;
  logic [17:0] b_in = '0;
  logic [47:0] c_in = '0;
  logic [47:0] casc_in = '0;
  logic        use_pre = 1'b0;
  logic [1:0]  add_sel = 2'd0;
  logic [47:0] p0, k0, p1, k1;

  always #4 clk = ~clk;

  premul_slice u0 (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .d_in(d_in), .b_in(b_in),
    .c_in(c_in), .casc_in(casc_in), .use_pre(use_pre), .add_sel(add_sel),
    .p_out(p0), .casc_out(k0)
  );

  premul_slice #(.AREG(0), .DREG(0), .MREG(0), .PREG(1)) u1 (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .d_in(d_in), .b_in(b_in),
    .c_in(c_in), .casc_in(casc_in), .use_pre(use_pre), .add_sel(add_sel),
    .p_out(p1), .casc_out(k1)
  );

  typedef struct packed {
    logic [47:0] term;
    logic [1:0]  sel;
    logic [47:0] c;
    logic [47:0] k;
  } op_t;

  int    checks = 0;
  int    errors = 0;
  string tag = "R7";
  op_t   h0, h1;
  logic [47:0] e0 = '0, e1 = '0;

  function automatic logic [24:0] pre_of(logic [29:0] a, logic [24:0] d, logic up);
    return up ? (a[24:0] + d) : a[24:0];
  endfunction

  function automatic logic [47:0] term_of(logic [24:0] pr, logic [17:0] b);
    logic signed [47:0] x, y, r;
    x = $signed({{23{pr[24]}}, pr});
    y = $signed({{30{b[17]}}, b});
    r = x * y;
    return r;
  endfunction

  function automatic logic [47:0] apply(op_t o, logic [47:0] p);
    case (o.sel)
      2'd0:    return o.term;
      2'd1:    return o.term + o.c;
      2'd2:    return o.term + o.k;
      default: return o.term + p;
    endcase
  endfunction

  function automatic op_t cur_op();
    op_t o;
    o.term = term_of(pre_of(a_in, d_in, use_pre), b_in);
    o.sel  = add_sel;
    o.c    = c_in;
    o.k    = casc_in;
    return o;
  endfunction

  task automatic chk(string t, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step();
    op_t cur, src;
    @(posedge clk);
    cur = cur_op();
    if (rst) begin
      e0 = '0; e1 = '0; h0 = '0; h1 = '0;
    end else if (ce) begin
      src = h1;
      h1  = h0;
      h0  = cur;
      e0  = apply(src, e0);
      e1  = apply(cur, e1);
    end
    @(negedge clk);
    chk({tag, " u0"}, p0, e0);
    chk({tag, " u1"}, p1, e1);
    chk("R5 u0 cascade", k0, p0);
    chk("R5 u1 cascade", k1, p1);
  endtask

  task automatic drive(logic [29:0] a, logic [24:0] d, logic [17:0] b,
                       logic [47:0] c, logic [47:0] k, logic up, logic [1:0] s);
    a_in = a; d_in = d; b_in = b; c_in = c; casc_in = k; use_pre = up; add_sel = s;
  endtask

  task automatic idle(int n);
    drive('0, '0, '0, '0, '0, 1'b0, 2'd0);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    h0 = '0; h1 = '0;
    void'($urandom(32'd2024));
    // R7: reset state
    tag = "R7 reset";
    for (int i = 0; i < 3; i++) step();
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset u0", p0, 48'd0);
    chk("R7 reset u1", p1, 48'd0);

    // R6: latency of a lone product, zeros after it
    tag = "R6 latency";
    drive(30'd5, 25'd0, 18'd3, '0, '0, 1'b0, 2'd0);
    step();
    idle(4);

    // R2: upper A bits ignored, pre-adder on and off
    tag = "R2 preadd";
    drive(30'h3E00_0007, 25'd2, 18'd1, '0, '0, 1'b0, 2'd0); step();
    drive(30'h3E00_0007, 25'd2, 18'd1, '0, '0, 1'b1, 2'd0); step();
    // R2: pre-adder wraps at 25 bits: 0x0FFFFFF + 1 -> -2^24
    drive(30'h00FF_FFFF, 25'd1, 18'd1, '0, '0, 1'b1, 2'd0); step();
    idle(3);
    chk("R2 wrap u1 reference", term_of(pre_of(30'h00FF_FFFF, 25'd1, 1'b1), 18'd1),
        48'hFFFF_FF00_0000);

    // R3: most negative operands
    tag = "R3 signed";
    drive(30'h0100_0000, 25'd0, 18'h20000, '0, '0, 1'b0, 2'd0); step();
    idle(3);

    // R4: accumulation, cascade and C addends
    tag = "R4 accumulate";
    for (int i = 0; i < 6; i++) begin
      drive(30'd1, 25'd0, 18'd7, '0, '0, 1'b0, 2'd3); step();
    end
    tag = "R4 cascade";
    drive(30'd2, 25'd0, 18'd3, 48'd99, 48'd123456, 1'b0, 2'd2); step();
    tag = "R4 direct";
    drive(30'd2, 25'd0, 18'd3, 48'd99, 48'd123456, 1'b0, 2'd1); step();
    idle(3);

    // R9: modulo 2^48 wrap
    tag = "R9 wrap";
    drive(30'd1, 25'd0, 18'd1, 48'h7FFF_FFFF_FFFF, '0, 1'b0, 2'd1); step();
    idle(3);

    // R8: frozen pipeline with changing inputs
    tag = "R8 hold";
    drive(30'd9, 25'd0, 18'd9, '0, '0, 1'b0, 2'd3); step(); step();
    ce = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive($urandom(), $urandom(), $urandom(), {$urandom(), $urandom()},
            {$urandom(), $urandom()}, 1'b1, 2'd3);
      step();
    end
    ce = 1'b1;

    // R7: reset in the middle of an accumulation
    tag = "R7 midstream";
    drive(30'd3, 25'd0, 18'd5, '0, '0, 1'b0, 2'd3); step();
    rst = 1'b1; ce = 1'b0; step();
    rst = 1'b0; ce = 1'b1; step(); step();

    // R1: constrained random mix
    tag = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      drive($urandom(), $urandom(), $urandom(), {$urandom(), $urandom()},
            {$urandom(), $urandom()}, 1'($urandom()), 2'($urandom()));
      if ($urandom_range(3) == 0) add_sel = 2'd3;
      ce  = ($urandom_range(6) != 0);
      rst = ($urandom_range(199) == 0);
      step();
    end
    rst = 1'b0; ce = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule